// File: doc/BRIEF.md
# Idle-Qualified Clock Enable Controller

This block drives clock-enable signals for two sets of clock domains. The first set is hint-controlled. Software writes one hint bit per domain, and each domain reports whether it is idle. A hint of 1 keeps that domain's clock running. A hint of 0 does not stop the clock by itself: it only allows the clock to stop, and the clock stops only while the domain also reports idle. The enable that results is reported back in a read-only status register, so software can see the real state of each domain's clock.

The second set is direct-controlled. Each of these domains has one enable bit, and that bit gates its clock with no idle qualification. Every enable, hint and status bit comes out of reset at 1, so all clocks run after reset.

The idle inputs may come from other timing contexts, so each one passes through a two-flop synchroniser before the decision uses it. The gating decision and the status bit are loaded from the same next-state value in the same cycle, so the status bit and the enable output always agree. Software reaches the registers through a simple write strobe with an address, and through a combinational read port.

Top module: `clk_hint_gate`

## Requirements
- R1: After reset, all hint bits, direct-enable bits, hint enables (`hint_en`) and status bits are 1. Register reads show all ones in the implemented bit positions: address 0 (hint) reads 0xF and address 1 (direct) reads 0x7 with the default widths.
- R2: A domain whose hint bit is 1 keeps `hint_en` at 1, whatever its idle input does.
- R3: A domain whose hint bit is 0 keeps `hint_en` at 1 while its synchronised idle input is 0 (busy).
- R4: A domain whose hint bit is 0 turns `hint_en` off when its idle input goes to 1. The change appears on the third rising edge after the idle input changes: two synchroniser stages, then the decision register.
- R5: A disabled domain turns back on at the rising edge after the edge that stores a hint of 1. If instead its idle input drops to 0, it turns back on at the third rising edge after the drop.
- R6: `hint_status` equals `hint_en` in every cycle. Reading address 2 returns the same bits.
- R7: Direct enable bits drive `direct_en` as soon as the write edge stores them, and the idle inputs have no effect on them.
- R8: Address map on a 2-bit address: 0 is the hint register, 1 is the direct-enable register, 2 is the read-only status register, and 3 is unused. Writes to addresses 2 and 3 change no register. Address 3 reads 0, and bits above each register's width read 0.
- R9: Each hinted domain is decided on its own, so different domains can be on and off at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 hint, 1 direct, 2 status, 3 unused) |
| wr_data | input | DATA_W | Write data, with bit i belonging to domain i |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Combinational read data |
| idle_i | input | NUM_HINT | Idle flag per hinted domain (1 means idle) |
| hint_en | output | NUM_HINT | Clock enable per hinted domain |
| hint_status | output | NUM_HINT | Registered status, equal to `hint_en` |
| direct_en | output | NUM_DIRECT | Clock enable per direct domain |

## Verification
The decision is tried over the hint/idle combinations:
- all hints at 1 with every domain idle, which separates "hint forces on" from "idle forces off";
- all hints at 0 with every domain busy, which shows that a 0 hint alone stops nothing;
- all hints at 0 with every domain idle, which is the only pattern that turns clocks off;
- mixed per-domain patterns, which expose cross-domain wiring or swapped bits.

Directed steps check the exact edge on which idle takes effect and the edge on which a hint of 1 restores the clock. They also check that writes to the read-only and unused addresses are ignored, and that direct enables ignore idle.

// File: rtl/clk_hint_gate_pkg.sv
package clk_hint_gate_pkg;

    typedef enum logic [1:0] {
        ADDR_HINT   = 2'd0,
        ADDR_DIRECT = 2'd1,
        ADDR_STATUS = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/clk_hint_sync.sv
module clk_hint_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = async_i;
        s_d.stage2 = s_q.stage1;
    end

    // Reset to busy (0) so that no clock stops before real idle arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stage2;
endmodule

// File: rtl/clk_hint_regs.sv
module clk_hint_regs
    import clk_hint_gate_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_HINT   = 4,
    parameter int NUM_DIRECT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [1:0]            rd_addr,
    input  logic [NUM_HINT-1:0]   status_i,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_HINT-1:0]   hint_o,
    output logic [NUM_DIRECT-1:0] direct_o
);
    localparam int HINT_PAD   = DATA_W - NUM_HINT;
    localparam int DIRECT_PAD = DATA_W - NUM_DIRECT;

    typedef struct packed {
        logic [NUM_HINT-1:0]   hint;
        logic [NUM_DIRECT-1:0] direct;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                ADDR_HINT:   r_d.hint   = wr_data[NUM_HINT-1:0];
                ADDR_DIRECT: r_d.direct = wr_data[NUM_DIRECT-1:0];
                default:     r_d        = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            ADDR_HINT:   rd_data = {{HINT_PAD{1'b0}}, r_q.hint};
            ADDR_DIRECT: rd_data = {{DIRECT_PAD{1'b0}}, r_q.direct};
            ADDR_STATUS: rd_data = {{HINT_PAD{1'b0}}, status_i};
            default:     rd_data = '0;
        endcase
    end

    assign hint_o   = r_q.hint;
    assign direct_o = r_q.direct;
endmodule

// File: rtl/clk_hint_decide.sv
module clk_hint_decide #(
    parameter int NUM_HINT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_HINT-1:0] hint_i,
    input  logic [NUM_HINT-1:0] idle_i,
    output logic [NUM_HINT-1:0] en_o,
    output logic [NUM_HINT-1:0] status_o
);
    typedef struct packed {
        logic [NUM_HINT-1:0] en;
        logic [NUM_HINT-1:0] status;
    } dec_t;

    dec_t d_d, d_q;
    logic [NUM_HINT-1:0] keep_on;

    // A domain stays on unless its hint permits stopping and it is idle
    for (genvar i = 0; i < NUM_HINT; i++) begin : g_dom
        assign keep_on[i] = hint_i[i] | ~idle_i[i];
    end

    always_comb begin
        d_d        = d_q;
        d_d.en     = keep_on;
        d_d.status = keep_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '1;
        end else begin
            d_q <= d_d;
        end
    end

    assign en_o     = d_q.en;
    assign status_o = d_q.status;
endmodule

// File: rtl/clk_hint_gate.sv
module clk_hint_gate #(
    parameter int DATA_W     = 32,
    parameter int NUM_HINT   = 4,
    parameter int NUM_DIRECT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [1:0]            rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [NUM_HINT-1:0]   idle_i,
    output logic [NUM_HINT-1:0]   hint_en,
    output logic [NUM_HINT-1:0]   hint_status,
    output logic [NUM_DIRECT-1:0] direct_en
);
    logic [NUM_HINT-1:0]   hint_reg;
    logic [NUM_DIRECT-1:0] direct_reg;
    logic [NUM_HINT-1:0]   idle_s;

    clk_hint_sync #(.WIDTH(NUM_HINT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (idle_i),
        .sync_o  (idle_s)
    );

    clk_hint_regs #(
        .DATA_W     (DATA_W),
        .NUM_HINT   (NUM_HINT),
        .NUM_DIRECT (NUM_DIRECT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .status_i (hint_status),
        .rd_data  (rd_data),
        .hint_o   (hint_reg),
        .direct_o (direct_reg)
    );

    clk_hint_decide #(.NUM_HINT(NUM_HINT)) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .hint_i   (hint_reg),
        .idle_i   (idle_s),
        .en_o     (hint_en),
        .status_o (hint_status)
    );

    assign direct_en = direct_reg;
endmodule

// File: rtl/clk_hint_gate_chk.sv
module clk_hint_gate_chk #(
    parameter int DATA_W     = 32,
    parameter int NUM_HINT   = 4,
    parameter int NUM_DIRECT = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [1:0]            wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic [NUM_HINT-1:0]   hint_reg,
    input logic [NUM_DIRECT-1:0] direct_reg,
    input logic [NUM_HINT-1:0]   idle_s,
    input logic [NUM_HINT-1:0]   hint_en,
    input logic [NUM_HINT-1:0]   hint_status,
    input logic [NUM_DIRECT-1:0] direct_en
);
    // R6
    status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hint_status == hint_en);

    // R2
    hint_forces_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((hint_en & $past(hint_reg)) == $past(hint_reg)));

    // R3
    busy_stays_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((~hint_en & ~$past(idle_s)) == '0));

    // R4
    idle_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((hint_en & ~$past(hint_reg) & $past(idle_s)) == '0));

    // R7
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> (direct_en == $past(wr_data[NUM_DIRECT-1:0])));

    // R8
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[1]) |=> ($stable(hint_reg) && $stable(direct_reg)));
endmodule

bind clk_hint_gate clk_hint_gate_chk #(
    .DATA_W     (DATA_W),
    .NUM_HINT   (NUM_HINT),
    .NUM_DIRECT (NUM_DIRECT)
) u_chk (.*);

// File: tb/test_clk_hint_gate.sv
module test_clk_hint_gate;
    localparam int DATA_W     = 32;
    localparam int NUM_HINT   = 4;
    localparam int NUM_DIRECT = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic [1:0]            wr_addr = '0;
    logic [DATA_W-1:0]     wr_data = '0;
    logic [1:0]            rd_addr = '0;
    logic [DATA_W-1:0]     rd_data;
    logic [NUM_HINT-1:0]   idle_i = '0;
    logic [NUM_HINT-1:0]   hint_en;
    logic [NUM_HINT-1:0]   hint_status;
    logic [NUM_DIRECT-1:0] direct_en;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    clk_hint_gate #(
        .DATA_W     (DATA_W),
        .NUM_HINT   (NUM_HINT),
        .NUM_DIRECT (NUM_DIRECT)
    ) i_clk_hint_gate (.*);

    // Each entry: {hint[3:0], idle[3:0], expected hint_en[3:0]}
    localparam logic [11:0] VECS [6] = '{
        {4'b1111, 4'b1111, 4'b1111},  // R2 hint forces on
        {4'b0000, 4'b0000, 4'b1111},  // R3 busy keeps on
        {4'b0000, 4'b1111, 4'b0000},  // R4 idle + hint 0 gates off
        {4'b0101, 4'b1111, 4'b0101},  // R9 mixed hints
        {4'b0000, 4'b0011, 4'b1100},  // R9 mixed idle
        {4'b1010, 4'b0110, 4'b1011}   // R9 mixed both
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [DATA_W-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        logic [DATA_W-1:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 hint_en", 32'(hint_en), 32'hF);
        check("R1 status", 32'(hint_status), 32'hF);
        check("R1 direct_en", 32'(direct_en), 32'h7);
        reg_read(2'd0, rv); check("R1 hint reg", rv, 32'hF);
        reg_read(2'd1, rv); check("R1 direct reg", rv, 32'h7);

        // Vector table
        foreach (VECS[k]) begin
            @(negedge clk);
            idle_i = VECS[k][7:4];
            wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'(VECS[k][11:8]);
            @(negedge clk);
            wr_en = 1'b0;
            repeat (3) @(negedge clk);
            check("R2/R3/R4/R9 hint_en", 32'(hint_en), 32'(VECS[k][3:0]));
            check("R6 status", 32'(hint_status), 32'(VECS[k][3:0]));
            reg_read(2'd2, rv); check("R6 status read", rv, 32'(VECS[k][3:0]));
        end

        // R4 exact timing: hint 0, all busy, then domain 0 goes idle
        reg_write(2'd0, 32'h0);
        idle_i = 4'b0000;
        repeat (3) @(negedge clk);
        check("R3 busy on", 32'(hint_en), 32'hF);
        idle_i = 4'b0001;
        @(negedge clk); @(negedge clk);
        check("R4 still on after two edges", 32'(hint_en), 32'hF);
        @(negedge clk);
        check("R4 off at third edge", 32'(hint_en), 32'hE);
        check("R6 status tracks off", 32'(hint_status), 32'hE);

        // R5 hint 1 restores at edge after storing edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5 not yet on", 32'(hint_en), 32'hE);
        @(negedge clk);
        check("R5 on after hint", 32'(hint_en), 32'hF);

        // R5 idle drop restores at third edge
        reg_write(2'd0, 32'h0);
        repeat (2) @(negedge clk);
        check("R4 off again", 32'(hint_en), 32'hE);
        idle_i = 4'b0000;
        @(negedge clk); @(negedge clk);
        check("R5 still off after two edges", 32'(hint_en), 32'hE);
        @(negedge clk);
        check("R5 on at third edge", 32'(hint_en), 32'hF);

        // R7 direct enables ignore idle
        idle_i = 4'b1111;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h2;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 direct_en after write", 32'(direct_en), 32'h2);
        repeat (4) @(negedge clk);
        check("R7 direct_en with idle", 32'(direct_en), 32'h2);
        reg_read(2'd1, rv); check("R7 direct read", rv, 32'h2);

        // R8 read-only and unused addresses
        reg_write(2'd0, 32'hFFFF_FFF5);
        reg_read(2'd0, rv); check("R8 upper bits zero", rv, 32'h5);
        reg_write(2'd2, 32'h0);
        reg_write(2'd3, 32'h0);
        reg_read(2'd0, rv); check("R8 hint kept", rv, 32'h5);
        reg_read(2'd1, rv); check("R8 direct kept", rv, 32'h2);
        reg_read(2'd3, rv); check("R8 unused reads zero", rv, 32'h0);
        repeat (2) @(negedge clk);
        check("R8 hint_en unchanged", 32'(hint_en), 32'h5);

        // R1 reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 async reset enables", 32'(hint_en), 32'hF);
        check("R1 async reset direct", 32'(direct_en), 32'h7);
        rst_n = 1'b1;

        finish_run();
    end
endmodule